// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the address stream for a single DMA channel. Software fills a small set of registers: a base address, an element count per row, a row count, a signed element step, a signed row step, an element width and a mode word. It then writes a start bit. From then on the block offers one address per cycle on a valid/ready handshake and moves to the next address only when the consumer accepts the current one. Data movement, descriptor fetches and bus arbitration belong to the surrounding logic.

The element step is applied between elements of the same row. The row step is applied in its place when a row is left for the next one. Each step is signed and is scaled by the element width. The two steps have no ordering constraint, so the row step may be zero, negative or smaller than the element step. This lets an interleaved stream be separated as it is transferred. A run either stops after the last element or reloads itself and repeats without end. A one-cycle pulse marks the end of every row, if enabled, and the end of the whole buffer. Each pulse also sets a sticky status bit that software clears by writing a 1 to it.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset the channel is idle: `busy`, `addr_valid`, `irq_row` and `irq_buf` are low, and the status register (index 5) and base register (index 0) read as zero.
- R2: In one-dimensional mode (mode bit 0 = 0) the channel issues exactly N addresses, base + k·E·S for k = 0..N-1. N is the element count (bits 15:0 of index 1, with 0 meaning 65536), E is the signed element step (bits 15:0 of index 2) and S is the element width. The row count field is ignored.
- R3: In two-dimensional mode (mode bit 0 = 1) there are M rows of N elements, where M is bits 31:16 of index 1 and 0 means 65536. Within a row, each address follows the previous one by E·S. The first address of each following row is the last address of the previous row plus O·S, where O is the signed row step in bits 31:16 of index 2. O may be zero, negative or smaller than E.
- R4: The element width S is 1, 2 or 4 bytes for mode bits 4:3 = 0, 1 or 2 (3 also selects 4). The address is 32 bits wide and wraps modulo 2^32.
- R5: `addr_out` and `addr_valid` hold steady while `addr_ready` is low. The address advances only on a cycle in which valid and ready are both high.
- R6: With mode bit 1 = 0 (stop), the cycle after the last element is accepted `busy` and `addr_valid` are low, and they stay low until a new start.
- R7: With mode bit 1 = 1 (circular), the cycle after the last element is accepted the channel is still busy and presents the base address again with full counts.
- R8: With mode bit 2 = 1 in two-dimensional mode, `irq_row` is high for the one cycle after the last element of each row is accepted. With mode bit 2 = 0, or in one-dimensional mode, it stays low.
- R9: `irq_buf` is high for exactly the cycle after the last element of the buffer is accepted.
- R10: Status bit 0 (row) and bit 1 (buffer) are set with the matching pulse and stay set. Writing 1 to a bit of index 5 clears that bit, and writing 0 leaves it unchanged.
- R11: While `busy` is high, writes to indices 0 to 3 and start requests have no effect.
- R12: Writing 1 to bit 1 of index 4 (abort) makes `busy` and `addr_valid` low in the next cycle, with no interrupt pulse. Bit 0 of index 4 is start and reads back as `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| addr_valid | output | 1 | An address is offered |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_out | output | 32 | Current element byte address |
| busy | output | 1 | Channel is running |
| irq_row | output | 1 | One-cycle row-complete pulse |
| irq_buf | output | 1 | One-cycle buffer-complete pulse |

## Verification
Both modes are swept against all three element widths and four stride pairs: a row step below, above and equal to zero, and a negative element step. A wrong sign extension, a wrong scale factor, or a row step applied at the wrong position each produces its own distinct address mismatch. Every stride case is run twice, once with ready held high and once with periodic stalls, which separates advance-on-handshake from advance-per-cycle. Further runs cover a maximal 65536-element row (count field 0), circular reload across two passes, an abort in mid-run, and register writes made while busy.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 16;
  localparam int IDX_W    = 3;
  localparam int REM_W    = CNT_W + 1;

  localparam logic [IDX_W-1:0] IDX_BASE   = 3'd0;
  localparam logic [IDX_W-1:0] IDX_COUNT  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_STEP   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_MODE   = 3'd3;
  localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd4;
  localparam logic [IDX_W-1:0] IDX_STAT   = 3'd5;

  typedef enum logic [1:0] {
    EW_BYTE = 2'd0,
    EW_HALF = 2'd1,
    EW_WORD = 2'd2,
    EW_WRD2 = 2'd3
  } ewidth_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  n_elem;
    logic [CNT_W-1:0]  n_rows;
    logic [CNT_W-1:0]  elem_step;
    logic [CNT_W-1:0]  row_step;
    logic              two_dim;
    logic              circular;
    logic              row_irq_en;
    ewidth_e           ewidth;
  } chan_cfg_t;
endpackage

// File: rtl/dma2d_cfg_regs.sv
module dma2d_cfg_regs
  import dma2d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output chan_cfg_t         cfg,
  output logic              start_req,
  output logic              abort_req
);
  chan_cfg_t cfg_q, cfg_d;
  logic      cfg_en;

  assign cfg_en    = we && !busy && (widx <= IDX_MODE);
  assign abort_req = we && (widx == IDX_CTRL) && wdata[1];
  assign start_req = we && (widx == IDX_CTRL) && wdata[0] && !wdata[1] && !busy;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_en) begin
      case (widx)
        IDX_BASE:  cfg_d.base = wdata[ADDR_W-1:0];
        IDX_COUNT: begin
          cfg_d.n_elem = wdata[CNT_W-1:0];
          cfg_d.n_rows = wdata[2*CNT_W-1:CNT_W];
        end
        IDX_STEP: begin
          cfg_d.elem_step = wdata[CNT_W-1:0];
          cfg_d.row_step  = wdata[2*CNT_W-1:CNT_W];
        end
        default: begin
          cfg_d.two_dim    = wdata[0];
          cfg_d.circular   = wdata[1];
          cfg_d.row_irq_en = wdata[2];
          cfg_d.ewidth     = ewidth_e'(wdata[4:3]);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q)); // R11
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker
  import dma2d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cfg_t         cfg,
  input  logic              start_req,
  input  logic              abort_req,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              row_end,
  output logic              buf_end
);
  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [REM_W-1:0]  erem_q, erem_d;
  logic [REM_W-1:0]  rrem_q, rrem_d;
  logic              step_en;
  logic              fire;
  logic [ADDR_W-1:0] elem_inc, row_inc;
  logic [REM_W-1:0]  elem_load, rows_load;

  function automatic logic [REM_W-1:0] load_count(input logic [CNT_W-1:0] c);
    return (c == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, c};
  endfunction

  function automatic logic [ADDR_W-1:0] scale(input logic [CNT_W-1:0] s,
                                               input ewidth_e w);
    logic [ADDR_W-1:0] x;
    x = {{(ADDR_W-CNT_W){s[CNT_W-1]}}, s};
    case (w)
      EW_BYTE: return x;
      EW_HALF: return x << 1;
      default: return x << 2;
    endcase
  endfunction

  assign elem_inc  = scale(cfg.elem_step, cfg.ewidth);
  assign row_inc   = scale(cfg.row_step, cfg.ewidth);
  assign elem_load = load_count(cfg.n_elem);
  assign rows_load = cfg.two_dim ? load_count(cfg.n_rows) : REM_W'(1);

  assign fire    = busy_q && ready && !abort_req;
  assign row_end = fire && (erem_q == REM_W'(1));
  assign buf_end = row_end && (rrem_q == REM_W'(1));
  assign step_en = start_req || abort_req || fire;

  always_comb begin
    busy_d = busy_q;
    addr_d = addr_q;
    erem_d = erem_q;
    rrem_d = rrem_q;
    if (abort_req) begin
      busy_d = 1'b0;
    end else if (start_req) begin
      busy_d = 1'b1;
      addr_d = cfg.base;
      erem_d = elem_load;
      rrem_d = rows_load;
    end else if (buf_end) begin
      busy_d = cfg.circular;
      addr_d = cfg.base;
      erem_d = elem_load;
      rrem_d = rows_load;
    end else if (row_end) begin
      addr_d = addr_q + row_inc;
      erem_d = elem_load;
      rrem_d = rrem_q - REM_W'(1);
    end else if (fire) begin
      addr_d = addr_q + elem_inc;
      erem_d = erem_q - REM_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      erem_q <= '0;
      rrem_q <= '0;
    end else if (step_en) begin
      busy_q <= busy_d;
      addr_q <= addr_d;
      erem_q <= erem_d;
      rrem_q <= rrem_d;
    end
  end

  assign valid = busy_q;
  assign addr  = addr_q;
  assign busy  = busy_q;

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ready && !abort_req) |=> (busy_q && $stable(addr_q))); // R5
  AST_COUNTS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((erem_q != '0) && (rrem_q != '0))); // R2
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_end && !cfg.circular) |=> !busy_q); // R6
  AST_CIRC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_end && cfg.circular) |=> (busy_q && (addr_q == cfg.base))); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !busy_q); // R12
endmodule

// File: rtl/dma2d_irq.sv
module dma2d_irq
  import dma2d_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       row_end,
  input  logic       buf_end,
  input  logic       two_dim,
  input  logic       row_irq_en,
  input  logic [1:0] clr_mask,
  output logic       irq_row,
  output logic       irq_buf,
  output logic [1:0] sticky
);
  logic       row_q, row_d;
  logic       buf_q, buf_d;
  logic [1:0] sticky_q, sticky_d;

  always_comb begin
    row_d    = row_end && two_dim && row_irq_en;
    buf_d    = buf_end;
    sticky_d = (sticky_q & ~clr_mask) | {buf_d, row_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q    <= 1'b0;
      buf_q    <= 1'b0;
      sticky_q <= 2'b00;
    end else begin
      row_q    <= row_d;
      buf_q    <= buf_d;
      sticky_q <= sticky_d;
    end
  end

  assign irq_row = row_q;
  assign irq_buf = buf_q;
  assign sticky  = sticky_q;

  AST_STICKY_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    irq_row |-> sticky_q[0]); // R10
  AST_STICKY_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    irq_buf |-> sticky_q[1]); // R10
  AST_ROW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !row_irq_en |=> !irq_row); // R8
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_out,
  output logic              busy,
  output logic              irq_row,
  output logic              irq_buf
);
  chan_cfg_t  cfg;
  logic       start_req, abort_req;
  logic       row_end, buf_end;
  logic [1:0] sticky;
  logic [1:0] clr_mask;
  logic       busy_w;

  assign clr_mask = (reg_we && (reg_addr == IDX_STAT)) ? reg_wdata[1:0] : 2'b00;

  dma2d_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .widx      (reg_addr),
    .wdata     (reg_wdata),
    .busy      (busy_w),
    .cfg       (cfg),
    .start_req (start_req),
    .abort_req (abort_req)
  );

  dma2d_walker u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .start_req (start_req),
    .abort_req (abort_req),
    .ready     (addr_ready),
    .valid     (addr_valid),
    .addr      (addr_out),
    .busy      (busy_w),
    .row_end   (row_end),
    .buf_end   (buf_end)
  );

  dma2d_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_end    (row_end),
    .buf_end    (buf_end),
    .two_dim    (cfg.two_dim),
    .row_irq_en (cfg.row_irq_en),
    .clr_mask   (clr_mask),
    .irq_row    (irq_row),
    .irq_buf    (irq_buf),
    .sticky     (sticky)
  );

  assign busy = busy_w;

  always_comb begin
    case (reg_addr)
      IDX_BASE:  reg_rdata = cfg.base;
      IDX_COUNT: reg_rdata = {cfg.n_rows, cfg.n_elem};
      IDX_STEP:  reg_rdata = {cfg.row_step, cfg.elem_step};
      IDX_MODE:  reg_rdata = {27'd0, cfg.ewidth, cfg.row_irq_en, cfg.circular, cfg.two_dim};
      IDX_CTRL:  reg_rdata = {31'd0, busy_w};
      IDX_STAT:  reg_rdata = {30'd0, sticky};
      default:   reg_rdata = '0;
    endcase
  end

  AST_VALID_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid == busy); // R6
  AST_BUF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_buf && !cfg.circular) |=> !irq_buf); // R9
endmodule

// File: tb/dma2d_addr_gen_tb_top.sv
module dma2d_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        addr_valid;
  logic        addr_ready;
  logic [31:0] addr_out;
  logic        busy;
  logic        irq_row;
  logic        irq_buf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma2d_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr_out(addr_out), .busy(busy),
    .irq_row(irq_row), .irq_buf(irq_buf)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    reg_addr = idx;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] st, input longint r,
      input longint c, input longint n, input logic signed [15:0] es,
      input logic signed [15:0] rs, input int w);
    longint sz, eb, rb, a;
    sz = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    eb = longint'(es) * sz;
    rb = longint'(rs) * sz;
    a  = longint'(st) + r * ((n - 1) * eb + rb) + c * eb;
    return a[31:0];
  endfunction

  // Runs a transfer for a number of passes; stall > 0 drops ready every stall-th cycle.
  task automatic run_xfer(input logic [31:0] st, input logic [15:0] ne, input logic [15:0] nr,
      input logic signed [15:0] es, input logic signed [15:0] rs, input int w,
      input bit td, input bit circ, input bit rie, input int stall, input int passes);
    longint n, m, r, c;
    int p, cyc;
    bit exp_row, exp_buf, prev_stall, done;
    logic [31:0] prev_a, rv;
    n = (ne == 0) ? 65536 : ne;
    m = td ? ((nr == 0) ? 65536 : nr) : 1;
    wr(3'd0, st);
    wr(3'd1, {nr, ne});
    wr(3'd2, {rs, es});
    wr(3'd3, {27'd0, w[1:0], rie, circ, td});
    wr(3'd5, 32'h3);
    wr(3'd4, 32'h1);
    r = 0; c = 0; p = 0; cyc = 0;
    exp_row = 0; exp_buf = 0; prev_stall = 0; done = 0; prev_a = 0;
    while (!done) begin
      check("R8", irq_row, exp_row);
      check("R9", irq_buf, exp_buf);
      if (prev_stall) check("R5", addr_out, prev_a);
      exp_row = 0; exp_buf = 0;
      if (p == passes) begin
        done = 1;
      end else begin
        addr_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
        check("R5", addr_valid, 1'b1);
        prev_stall = !addr_ready;
        prev_a = addr_out;
        if (addr_ready) begin
          check(td ? "R3" : "R2", addr_out, exp_addr(st, r, c, n, es, rs, w));
          if (c == n - 1) begin
            c = 0;
            exp_row = td && rie;
            if (r == m - 1) begin
              r = 0; p++; exp_buf = 1;
            end else r++;
          end else c++;
        end
        cyc++;
        @(negedge clk);
        addr_ready = 1'b0;
      end
    end
    if (circ) begin
      check("R7", busy, 1'b1);
      check("R7", addr_out, st);
      wr(3'd4, 32'h2);
      check("R12", busy, 1'b0);
      check("R12", addr_valid, 1'b0);
    end else begin
      check("R6", busy, 1'b0);
      check("R6", addr_valid, 1'b0);
      @(negedge clk);
      check("R6", busy, 1'b0);
    end
    rd(3'd5, rv);
    check("R10", rv, {30'd0, 1'b1, td && rie});
  endtask

  logic [31:0] v;

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 32'd0; addr_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", {busy, addr_valid, irq_row, irq_buf}, 4'd0);
    rd(3'd5, v); check("R1", v, 32'd0);
    rd(3'd0, v); check("R1", v, 32'd0);

    // R2 R3 R4 R5 sweep: widths x modes x stride pairs x ready patterns
    for (int w = 0; w < 3; w++) begin
      for (int td = 0; td < 2; td++) begin
        for (int k = 0; k < 4; k++) begin
          for (int s = 0; s < 2; s++) begin
            case (k)
              0: run_xfer(32'h0000_1000, 16'd3, 16'd3, 16'sd1, -16'sd3, w, td[0], 1'b0, 1'b1, s * 3, 1);
              1: run_xfer(32'h0000_2000, 16'd4, 16'd2, 16'sd3, 16'sd1, w, td[0], 1'b0, 1'b1, s * 3, 1);
              2: run_xfer(32'h0000_0008, 16'd2, 16'd3, -16'sd2, 16'sd5, w, td[0], 1'b0, 1'b0, s * 3, 1);
              default: run_xfer(32'hFFFF_FFF0, 16'd3, 16'd2, 16'sd4, 16'sd0, w, td[0], 1'b0, 1'b1, s * 3, 1);
            endcase
          end
        end
      end
    end

    // R7 circular, two passes with stalls; R8 row pulses
    run_xfer(32'h0000_4000, 16'd2, 16'd3, 16'sd2, -16'sd1, 1, 1'b1, 1'b1, 1'b1, 4, 2);
    // R2 count field 0 means 65536 elements
    run_xfer(32'h0001_0000, 16'd0, 16'd7, 16'sd1, 16'sd0, 0, 1'b0, 1'b0, 1'b0, 0, 1);

    // R10 write-one-to-clear on status
    run_xfer(32'h0000_0100, 16'd2, 16'd2, 16'sd1, 16'sd1, 2, 1'b1, 1'b0, 1'b1, 0, 1);
    wr(3'd5, 32'h2);
    rd(3'd5, v); check("R10", v, 32'h1);
    wr(3'd5, 32'h0);
    rd(3'd5, v); check("R10", v, 32'h1);
    wr(3'd5, 32'h1);
    rd(3'd5, v); check("R10", v, 32'h0);

    // R11 writes while busy are ignored; R12 abort
    wr(3'd0, 32'h0000_5000);
    wr(3'd1, {16'd2, 16'd4});
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h1);
    check("R11", busy, 1'b1);
    wr(3'd0, 32'hDEAD_0000);
    wr(3'd3, 32'h1F);
    wr(3'd4, 32'h1);
    rd(3'd0, v); check("R11", v, 32'h0000_5000);
    rd(3'd3, v); check("R11", v, 32'h0);
    check("R11", addr_out, 32'h0000_5000);
    wr(3'd4, 32'h2);
    check("R12", busy, 1'b0);
    check("R12", addr_valid, 1'b0);
    check("R12", {irq_row, irq_buf}, 2'b00);
    rd(3'd4, v); check("R12", v, 32'h0);
    wr(3'd4, 32'h1);
    check("R11", addr_out, 32'h0000_5000);
    wr(3'd4, 32'h2);
    check("R12", busy, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule